// File: doc/BRIEF.md
# Dual-Clock Cascadable FIFO

This block is an 18-bit first-in first-out buffer. It is written from one clock and read from another. Storage is an internal two-port register array whose depth is a parameter: 256 words by default, and 256, 512, 1024, 2048 or 4096 in practice. The read side works in show-ahead fashion. While the block drives its outputs and holds data, `rd_data` already presents the oldest word, and a read strobe discards that word at the next read-clock edge. The status outputs are a full flag, an empty flag and an active-low half-full flag. The half-full flag is set by write activity and released by read activity.

Identical instances can be cascaded into a deeper buffer. With `chain_en` high, each instance hands a write token and a read token to its neighbour. An instance passes the write token with a one-cycle pulse on `wr_tok_out` when it writes its last array location. It passes the read token with a pulse on `rd_tok_out` when it reads its last location. The last instance's outputs loop back to the first one's inputs. Write and read strobes go to every instance in parallel, and only the token holder acts on them. The data outputs of the instances are ORed together, because an instance that does not drive its outputs presents zero.

Pointers cross between the clock domains as Gray codes through two-flop synchronisers. Reset is asynchronous and active low, and its release is synchronised separately in each domain. Both clocks may run while reset is held.

Top module: `cascade_fifo`

## Requirements
- R1: After reset, `empty` is 1, `full` is 0 and `half_n` is 1. `rd_data` is all zeros, and `rd_drv` is 1 when `out_en_n` is 0.
- R2: Words are returned in the order they were written. `rd_data` shows the oldest stored word before the read edge that removes it.
- R3: `full` rises on the write edge that stores word number DEPTH. A write strobe while `full` is 1 stores nothing, and that word never appears at the read side.
- R4: A read strobe while `empty` is 1 changes no pointer. `empty` stays 1, and the next word written is the next word read.
- R5: A write that raises the stored count above DEPTH/2 drives `half_n` to 0 on that same write-clock edge.
- R6: `half_n` returns to 1 on the read-clock edge at which the stored count drops to DEPTH/2 or below. It stays 0 while the count is above DEPTH/2.
- R7: `wr_tok_out` is high during the write-clock cycle in which an accepted write targets the last array location, which is every DEPTH-th accepted write. It is low otherwise.
- R8: `rd_tok_out` is high during the read-clock cycle in which an accepted read takes the last array location, which is every DEPTH-th accepted read. It is low otherwise.
- R9: With `out_en_n` at 1, `rd_drv` is 0 and `rd_data` is all zeros. With `out_en_n` at 0, an instance that holds read access drives `rd_drv` to 1. It presents the oldest word, or zeros when it is empty.
- R10: With `chain_en` at 1, only the instance with `chain_head` at 1 holds the two tokens after reset. An instance accepts writes only while it holds the write token, and reads only while it holds the read token. It gains a token on a pulse at the matching input. Two chained instances therefore hold 2*DEPTH words, in order.
- R11: With `chain_en` at 0, an instance always holds both tokens, whatever `chain_head` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W | Word to store |
| rd_en | input | 1 | Read strobe, discards the presented word |
| out_en_n | input | 1 | Active-low output enable |
| rd_data | output | DATA_W | Oldest word, or zeros when not driving or empty |
| rd_drv | output | 1 | High while this instance drives the read data |
| chain_en | input | 1 | Enables token passing between cascaded instances |
| chain_head | input | 1 | Marks the instance that holds both tokens after reset |
| wr_tok_in | input | 1 | Write-token pulse from the previous instance (write clock) |
| wr_tok_out | output | 1 | Pulse on a write into the last location |
| rd_tok_in | input | 1 | Read-token pulse from the previous instance (read clock) |
| rd_tok_out | output | 1 | Pulse on a read from the last location |
| full | output | 1 | No free location, write clock domain |
| empty | output | 1 | No stored word, read clock domain |
| half_n | output | 1 | Low while more than DEPTH/2 words are stored |

## Verification
A wrong pointer shows within one operation. A missed or duplicated increment on either side shifts every later word of the sweep, so the first show-ahead compare after that point mismatches. It also moves the token pulses off every sixteenth operation. A broken half-full toggle pair appears on the edge that crosses the threshold, because the flag is compared right after every write and every read. A token that is not handed over leaves the second instance empty, or lets the first instance take words past its capacity. The chained read-back then mismatches at the seventeenth word.

// File: rtl/cfifo_pkg.sv
package cfifo_pkg;
  // Number of flops in each clock-domain crossing chain.
  localparam int unsigned CFIFO_SYNC_STAGES = 2;
  // Default word width of the buffer.
  localparam int unsigned CFIFO_DATA_W = 18;
endpackage

// File: rtl/cfifo_sync.sv
module cfifo_sync
  import cfifo_pkg::*;
#(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [CFIFO_SYNC_STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= d;
  end

  for (genvar s = 1; s < CFIFO_SYNC_STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[CFIFO_SYNC_STAGES-1];
endmodule

// File: rtl/cfifo_ram.sv
module cfifo_ram #(
  parameter int unsigned W     = 18,
  parameter int unsigned DEPTH = 256
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] wa,
  input  logic [W-1:0]             wd,
  input  logic [$clog2(DEPTH)-1:0] ra,
  output logic [W-1:0]             rd
);
  logic [W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[wa] <= wd;
  end

  assign rd = cells[ra];
endmodule

// File: rtl/cfifo_wr_side.sv
module cfifo_wr_side #(
  parameter int unsigned DEPTH = 256
) (
  input  logic                     wr_clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic                     chain_en,
  input  logic                     chain_head,
  input  logic                     tok_in,
  input  logic [$clog2(DEPTH):0]   rgray_s,
  input  logic                     hf_r_s,
  output logic [$clog2(DEPTH)-1:0] waddr,
  output logic [$clog2(DEPTH):0]   wgray,
  output logic                     wr_fire,
  output logic                     full,
  output logic                     tok_out,
  output logic                     hf_w
);
  localparam int unsigned AW   = $clog2(DEPTH);
  localparam int unsigned PW   = AW + 1;
  localparam int unsigned HALF = DEPTH / 2;

  logic [1:0]    rst_pipe;
  logic          lrst_n;
  logic [PW-1:0] bin_q, bin_d, gray_q, gray_d, rbin_s, level;
  logic          flip_q, flip_d, held, held_d, hf_q, hf_d, tok_eff, at_last;

  // Reset asserts asynchronously and releases on the write clock.
  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign lrst_n = rst_pipe[1];

  always_comb begin
    for (int i = 0; i < PW; i++) rbin_s[i] = ^(rgray_s >> i);
    level   = bin_q - rbin_s;
    full    = (level == PW'(DEPTH));
    held    = chain_head ^ flip_q;
    tok_eff = !chain_en || held;
    wr_fire = wr_en && tok_eff && !full;
    at_last = (bin_q[AW-1:0] == AW'(DEPTH - 1));
    tok_out = wr_fire && at_last;
    bin_d   = bin_q + PW'(wr_fire);
    gray_d  = bin_d ^ (bin_d >> 1);
    held_d  = held;
    if (chain_en && tok_out) held_d = 1'b0;
    if (tok_in)              held_d = 1'b1;
    flip_d  = held_d ^ chain_head;
    hf_d    = hf_q;
    if (!(hf_q ^ hf_r_s) && wr_fire && (level >= PW'(HALF))) hf_d = !hf_q;
  end

  always_ff @(posedge wr_clk or negedge lrst_n) begin
    if (!lrst_n) begin
      bin_q  <= '0;
      gray_q <= '0;
      flip_q <= 1'b0;
      hf_q   <= 1'b0;
    end else begin
      bin_q  <= bin_d;
      gray_q <= gray_d;
      flip_q <= flip_d;
      hf_q   <= hf_d;
    end
  end

  assign waddr = bin_q[AW-1:0];
  assign wgray = gray_q;
  assign hf_w  = hf_q;
endmodule

// File: rtl/cfifo_rd_side.sv
module cfifo_rd_side #(
  parameter int unsigned DEPTH = 256
) (
  input  logic                     rd_clk,
  input  logic                     rst_n,
  input  logic                     rd_en,
  input  logic                     out_en_n,
  input  logic                     chain_en,
  input  logic                     chain_head,
  input  logic                     tok_in,
  input  logic [$clog2(DEPTH):0]   wgray_s,
  input  logic                     hf_w_s,
  output logic [$clog2(DEPTH)-1:0] raddr,
  output logic [$clog2(DEPTH):0]   rgray,
  output logic                     empty,
  output logic                     tok_out,
  output logic                     drv,
  output logic                     hf_r
);
  localparam int unsigned AW   = $clog2(DEPTH);
  localparam int unsigned PW   = AW + 1;
  localparam int unsigned HALF = DEPTH / 2;

  logic [1:0]    rst_pipe;
  logic          lrst_n;
  logic [PW-1:0] bin_q, bin_d, gray_q, gray_d, wbin_s, level, level_after;
  logic          flip_q, flip_d, held, held_d, hf_q, hf_d, tok_eff, at_last, rd_fire;

  // Reset asserts asynchronously and releases on the read clock.
  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign lrst_n = rst_pipe[1];

  always_comb begin
    for (int i = 0; i < PW; i++) wbin_s[i] = ^(wgray_s >> i);
    level       = wbin_s - bin_q;
    empty       = (level == '0);
    held        = chain_head ^ flip_q;
    tok_eff     = !chain_en || held;
    drv         = !out_en_n && tok_eff;
    rd_fire     = rd_en && tok_eff && !empty;
    at_last     = (bin_q[AW-1:0] == AW'(DEPTH - 1));
    tok_out     = rd_fire && at_last;
    bin_d       = bin_q + PW'(rd_fire);
    gray_d      = bin_d ^ (bin_d >> 1);
    level_after = level - PW'(rd_fire);
    held_d      = held;
    if (chain_en && tok_out) held_d = 1'b0;
    if (tok_in)              held_d = 1'b1;
    flip_d      = held_d ^ chain_head;
    hf_d        = hf_q;
    if ((hf_w_s ^ hf_q) && (level_after <= PW'(HALF))) hf_d = !hf_q;
  end

  always_ff @(posedge rd_clk or negedge lrst_n) begin
    if (!lrst_n) begin
      bin_q  <= '0;
      gray_q <= '0;
      flip_q <= 1'b0;
      hf_q   <= 1'b0;
    end else begin
      bin_q  <= bin_d;
      gray_q <= gray_d;
      flip_q <= flip_d;
      hf_q   <= hf_d;
    end
  end

  assign raddr = bin_q[AW-1:0];
  assign rgray = gray_q;
  assign hf_r  = hf_q;
endmodule

// File: rtl/cascade_fifo.sv
module cascade_fifo
  import cfifo_pkg::*;
#(
  parameter int unsigned DATA_W = CFIFO_DATA_W,
  parameter int unsigned DEPTH  = 256
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic              out_en_n,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_drv,
  input  logic              chain_en,
  input  logic              chain_head,
  input  logic              wr_tok_in,
  output logic              wr_tok_out,
  input  logic              rd_tok_in,
  output logic              rd_tok_out,
  output logic              full,
  output logic              empty,
  output logic              half_n
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned PW = AW + 1;

  logic [AW-1:0]     waddr, raddr;
  logic [PW-1:0]     w_gray, r_gray, w_gray_s, r_gray_s;
  logic              wr_fire, hf_w, hf_r, hf_w_s, hf_r_s;
  logic [DATA_W-1:0] ram_q;

  cfifo_wr_side #(.DEPTH(DEPTH)) u_wr (
    .wr_clk(wr_clk), .rst_n(rst_n), .wr_en(wr_en), .chain_en(chain_en),
    .chain_head(chain_head), .tok_in(wr_tok_in), .rgray_s(r_gray_s),
    .hf_r_s(hf_r_s), .waddr(waddr), .wgray(w_gray), .wr_fire(wr_fire),
    .full(full), .tok_out(wr_tok_out), .hf_w(hf_w)
  );

  cfifo_rd_side #(.DEPTH(DEPTH)) u_rd (
    .rd_clk(rd_clk), .rst_n(rst_n), .rd_en(rd_en), .out_en_n(out_en_n),
    .chain_en(chain_en), .chain_head(chain_head), .tok_in(rd_tok_in),
    .wgray_s(w_gray_s), .hf_w_s(hf_w_s), .raddr(raddr), .rgray(r_gray),
    .empty(empty), .tok_out(rd_tok_out), .drv(rd_drv), .hf_r(hf_r)
  );

  cfifo_sync #(.W(PW)) u_wptr_to_rd (.clk(rd_clk), .rst_n(rst_n), .d(w_gray), .q(w_gray_s));
  cfifo_sync #(.W(PW)) u_rptr_to_wr (.clk(wr_clk), .rst_n(rst_n), .d(r_gray), .q(r_gray_s));
  cfifo_sync #(.W(1))  u_hfw_to_rd  (.clk(rd_clk), .rst_n(rst_n), .d(hf_w),   .q(hf_w_s));
  cfifo_sync #(.W(1))  u_hfr_to_wr  (.clk(wr_clk), .rst_n(rst_n), .d(hf_r),   .q(hf_r_s));

  cfifo_ram #(.W(DATA_W), .DEPTH(DEPTH)) u_ram (
    .clk(wr_clk), .we(wr_fire), .wa(waddr), .wd(wr_data), .ra(raddr), .rd(ram_q)
  );

  // Show-ahead output, forced to zero when not driving or nothing is stored.
  assign rd_data = (rd_drv && !empty) ? ram_q : '0;
  // The two toggles differ exactly while the half-full condition is held.
  assign half_n  = ~(hf_w ^ hf_r);
endmodule

// File: rtl/cfifo_chk.sv
module cfifo_chk #(
  parameter int unsigned DEPTH = 256
) (
  input logic                   wr_clk,
  input logic                   rd_clk,
  input logic                   rst_n,
  input logic                   wr_en,
  input logic                   rd_en,
  input logic                   full,
  input logic                   empty,
  input logic                   wr_tok_out,
  input logic                   rd_tok_out,
  input logic [$clog2(DEPTH):0] w_gray,
  input logic [$clog2(DEPTH):0] r_gray
);
  // R3
  no_overflow_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (full && wr_en) |=> $stable(w_gray));

  // R4
  no_underflow_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (empty && rd_en) |=> $stable(r_gray));

  // R2
  wr_gray_step_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    $onehot0(w_gray ^ $past(w_gray)));

  // R2
  rd_gray_step_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    $onehot0(r_gray ^ $past(r_gray)));

  // R7
  wr_pulse_single_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    wr_tok_out |=> !wr_tok_out);

  // R8
  rd_pulse_single_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    rd_tok_out |=> !rd_tok_out);
endmodule

bind cascade_fifo cfifo_chk #(.DEPTH(DEPTH)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
  .full(full), .empty(empty), .wr_tok_out(wr_tok_out), .rd_tok_out(rd_tok_out),
  .w_gray(w_gray), .r_gray(r_gray)
);

// File: tb/tb_cascade_fifo.sv
module tb_cascade_fifo;
  localparam int unsigned W    = 18;
  localparam int unsigned D    = 16;
  localparam int unsigned HALF = D / 2;

  logic wclk = 1'b0;
  logic rclk = 1'b0;
  always #10 wclk = ~wclk;   // 50 MHz write clock
  always #13 rclk = ~rclk;   // unrelated read clock

  logic         rst_n, wr_en, rd_en, out_en_n, chain_en;
  logic [W-1:0] wr_data;
  logic         b_wr_en, b_rd_en;
  logic [W-1:0] a_q, b_q;
  logic         a_drv, b_drv, a_wto, b_wto, a_rto, b_rto;
  logic         a_full, b_full, a_empty, b_empty, a_half, b_half;

  assign b_wr_en = wr_en & chain_en;
  assign b_rd_en = rd_en & chain_en;

  cascade_fifo #(.DATA_W(W), .DEPTH(D)) dut (
    .wr_clk(wclk), .rd_clk(rclk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .out_en_n(out_en_n), .rd_data(a_q), .rd_drv(a_drv),
    .chain_en(chain_en), .chain_head(1'b1), .wr_tok_in(b_wto), .wr_tok_out(a_wto),
    .rd_tok_in(b_rto), .rd_tok_out(a_rto), .full(a_full), .empty(a_empty), .half_n(a_half)
  );

  cascade_fifo #(.DATA_W(W), .DEPTH(D)) dut_b (
    .wr_clk(wclk), .rd_clk(rclk), .rst_n(rst_n), .wr_en(b_wr_en), .wr_data(wr_data),
    .rd_en(b_rd_en), .out_en_n(out_en_n), .rd_data(b_q), .rd_drv(b_drv),
    .chain_en(chain_en), .chain_head(1'b0), .wr_tok_in(a_wto), .wr_tok_out(b_wto),
    .rd_tok_in(a_rto), .rd_tok_out(b_rto), .full(b_full), .empty(b_empty), .half_n(b_half)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [W-1:0] model [$];
  int wpos, rpos, cap, seq;

  function automatic logic [W-1:0] pat(input int k);
    logic [31:0] v;
    v = (k * 37 + 5) ^ (k << 9) ^ 32'h2A5A5;
    return v[W-1:0];
  endfunction

  task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [W-1:0] v);
    bit   acc, exp_pulse;
    logic pulse;
    acc       = model.size() < cap;
    exp_pulse = acc && (wpos == D - 1);
    @(negedge wclk);
    wr_en = 1'b1; wr_data = v;
    #1 pulse = a_wto | b_wto;
    check_eq("R7 write token pulse", {31'd0, pulse}, {31'd0, exp_pulse});
    @(negedge wclk);
    wr_en = 1'b0;
    if (acc) begin
      model.push_back(v);
      wpos = (wpos + 1) % D;
    end
  endtask

  task automatic do_read(input string req);
    bit   acc, exp_pulse;
    logic pulse;
    acc       = model.size() > 0;
    exp_pulse = acc && (rpos == D - 1);
    @(negedge rclk);
    if (acc) check_eq(req, a_q | b_q, model[0]);
    else     check_eq("R9 empty output zero", a_q | b_q, 0);
    rd_en = 1'b1;
    #1 pulse = a_rto | b_rto;
    check_eq("R8 read token pulse", {31'd0, pulse}, {31'd0, exp_pulse});
    @(negedge rclk);
    rd_en = 1'b0;
    if (acc) begin
      void'(model.pop_front());
      rpos = (rpos + 1) % D;
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge wclk);
    repeat (6) @(negedge rclk);
  endtask

  task automatic apply_reset(input bit chain);
    rst_n = 1'b0; chain_en = chain;
    model.delete(); wpos = 0; rpos = 0;
    cap = chain ? 2 * D : D;
    repeat (4) @(negedge wclk);
    rst_n = 1'b1;
    settle();
  endtask

  initial begin
    #4000000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; out_en_n = 1'b0;
    chain_en = 1'b0; wr_data = '0; seq = 0;
    apply_reset(1'b0);

    // R1 reset state
    check_eq("R1 empty", {31'd0, a_empty}, 1);
    check_eq("R1 full", {31'd0, a_full}, 0);
    check_eq("R1 half_n", {31'd0, a_half}, 1);
    check_eq("R1 data low", a_q, 0);
    check_eq("R1 drive", {31'd0, a_drv}, 1);
    // R11 non-chained instance holds access without being head
    check_eq("R11 tokens held", {31'd0, b_drv}, 1);

    // R4 read on empty moves nothing
    do_read("R4 empty read");
    check_eq("R4 still empty", {31'd0, a_empty}, 1);
    settle();
    do_write(18'h15A5A);
    settle();
    do_read("R4 next word after empty read");
    settle();

    // R9 output enable
    do_write(18'h3C3C3);
    settle();
    out_en_n = 1'b1;
    #1;
    check_eq("R9 released drive", {31'd0, a_drv}, 0);
    check_eq("R9 released data", a_q, 0);
    out_en_n = 1'b0;
    #1;
    check_eq("R9 enabled data", a_q, model[0]);
    do_read("R2 data");
    settle();

    // Sweep every fill level, pointers wrapping, with overflow at full depth
    for (int n = 1; n <= D; n++) begin
      for (int i = 0; i < n + ((n == D) ? 2 : 0); i++) begin
        do_write(pat(seq)); seq++;
        check_eq("R3 full flag", {31'd0, a_full}, {31'd0, model.size() == D});
        check_eq("R5 half flag after write", {31'd0, a_half}, {31'd0, !(model.size() > HALF)});
      end
      settle();
      while (model.size() > 0) begin
        do_read("R2 order");
        check_eq("R6 half flag after read", {31'd0, a_half}, {31'd0, !(model.size() > HALF)});
        check_eq("R4 empty flag", {31'd0, a_empty}, {31'd0, model.size() == 0});
      end
      do_read("R4 read past empty");
      settle();
    end

    // R10 two-instance chain
    apply_reset(1'b1);
    check_eq("R10 head drives", {31'd0, a_drv}, 1);
    check_eq("R10 tail idle", {31'd0, b_drv}, 0);
    for (int i = 0; i < 2 * D + 1; i++) begin
      do_write(pat(seq)); seq++;
      if (i == D - 1) begin
        check_eq("R10 head full", {31'd0, a_full}, 1);
        check_eq("R10 tail untouched", {31'd0, b_empty}, 1);
      end
    end
    settle();
    check_eq("R10 head full at end", {31'd0, a_full}, 1);
    check_eq("R10 tail full", {31'd0, b_full}, 1);
    for (int i = 0; i < 2 * D + 1; i++) begin
      do_read("R10 chained order");
      if (i == D - 1) begin
        check_eq("R10 tail takes read", {31'd0, b_drv}, 1);
        check_eq("R10 head releases", {31'd0, a_drv}, 0);
      end
    end
    settle();
    check_eq("R10 both empty", {31'd0, a_empty & b_empty}, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule